// File: doc/BRIEF.md
# Sleep-Exit Clock Stabilization Gate

This block decides when the CPU clock may run and whether the high-speed oscillator is enabled while the core passes through its two standby modes. A halt strobe stops the CPU clock and leaves both oscillators as they are. A sleep strobe also stops the CPU clock, and it turns the high-speed oscillator off. Before that, the block records whether the oscillator was running and whether the CPU was clocked from it. Any one of three wake sources ends either mode: a non-maskable interrupt, an input-port interrupt or a timer interrupt.

When sleep ends, the oscillator needs time to settle. If the CPU was running from the high-speed clock and the active-low wait option is asserted, the block loads an 8-bit preset into a down-counter. The counter is clocked by high-speed clock ticks, which arrive as a one-cycle tick input. The CPU clock stays gated until the counter underflows. Software chooses the preset so that the wait covers the oscillator's settling time. In every other case the gate opens one cycle after the wake event.

Top module: `sbc_standby_gate`

## Requirements
- R1: While halted, `cpu_clk_en` is 0, `osc_hi_en` follows `osc_hi_cfg` and `osc_lo_en` follows `osc_lo_cfg`; no oscillator is switched by halt.
- R2: In the cycle after `sleep_req` is accepted in run mode, `osc_hi_en` and `cpu_clk_en` are both 0, and they stay 0 until a wake event.
- R3: When sleep ends, the high-speed oscillator enable returns to the value `osc_hi_cfg` had when sleep was entered. During the stabilization wait, `osc_hi_en` is 1.
- R4: From sleep entry until the gate opens, `cpu_sel_hi` holds the clock select sampled at sleep entry. At all other times it follows `cpu_sel_hi_cfg`.
- R5: Any of `wake_nmi`, `wake_port` or `wake_timer` ends halt or sleep. A wake event that arrives in run mode has no effect.
- R6: A wake event from sleep starts the stabilization wait when `wait_en_n` is 0 and both the saved oscillator state and the saved clock select are 1. During the wait, `stab_wait` is 1 and `cpu_clk_en` is 0. The counter is loaded with `wait_preset`, and a preset of N gives a wait of N+1 ticks.
- R7: `stab_done` is high for exactly the one cycle in which a tick arrives while the counter is at 0. `cpu_clk_en` rises in the following cycle.
- R8: When sleep ends without a wait (because `wait_en_n` is 1, the oscillator was off, or the CPU was on the low-speed clock), `cpu_clk_en` is 1 and `stab_wait` is 0 in the cycle after the wake event.
- R9: Halt exit never waits. `cpu_clk_en` is 1 in the cycle after the wake event, whatever the values of `wait_en_n` and `wait_preset`.
- R10: If `halt_req` and `sleep_req` arrive in the same cycle, the block enters sleep. Entry strobes that arrive outside run mode are ignored.
- R11: After reset the block is in run mode: `cpu_clk_en` is 1, `stab_wait` is 0 and `stab_done` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| halt_req | input | 1 | One-cycle halt entry strobe |
| sleep_req | input | 1 | One-cycle sleep entry strobe |
| wake_nmi | input | 1 | Non-maskable interrupt wake source |
| wake_port | input | 1 | Input-port interrupt wake source |
| wake_timer | input | 1 | Timer interrupt wake source |
| osc_hi_cfg | input | 1 | Software enable for the high-speed oscillator |
| osc_lo_cfg | input | 1 | Software enable for the low-speed oscillator |
| cpu_sel_hi_cfg | input | 1 | Software CPU clock select, 1 = high-speed |
| wait_en_n | input | 1 | Stabilization wait option, 0 = wait enabled |
| wait_preset | input | CNT_W (8) | Counter preset, loaded on wake from sleep |
| hs_tick | input | 1 | One pulse per high-speed clock period |
| osc_hi_en | output | 1 | High-speed oscillator enable |
| osc_lo_en | output | 1 | Low-speed oscillator enable |
| cpu_sel_hi | output | 1 | Effective CPU clock select |
| cpu_clk_en | output | 1 | CPU clock gate, 1 = clock runs |
| stab_wait | output | 1 | High during the stabilization wait |
| stab_done | output | 1 | One-cycle pulse on counter underflow |

## Verification
Entry strobes, wake events and underflow each take effect one clock edge after they are sampled. `stab_done` is the one exception: it is combinational and appears in the same cycle as the tick that causes it. The bench therefore drives inputs on the falling edge and compares every output just before the next rising edge. At that point the state reflects all earlier edges and `stab_done` reflects the current tick. Directed checks of a strobe's effect are made in the cycle after the strobe. The wait length is confirmed by spacing ticks with idle cycles and checking that the gate stays closed until the cycle after the (N+1)th tick.

// File: rtl/sbc_pkg.sv
package sbc_pkg;

  typedef enum logic [1:0] {
    ST_RUN   = 2'd0,
    ST_HALT  = 2'd1,
    ST_SLEEP = 2'd2,
    ST_STAB  = 2'd3
  } sbc_state_e;

  // Wait is taken only when enabled (active-low option) and the CPU was
  // really running from a live high-speed oscillator before sleep.
  function automatic logic wait_needed(input logic opt_n,
                                       input logic osc_was_on,
                                       input logic sel_was_hi);
    return (!opt_n) && osc_was_on && sel_was_hi;
  endfunction

  // One down-count step; saturates at zero (underflow is flagged elsewhere).
  function automatic logic [7:0] count_step(input logic [7:0] cur);
    return (cur == 8'd0) ? 8'd0 : cur - 8'd1;
  endfunction

endpackage

// File: rtl/sbc_ctx_save.sv
module sbc_ctx_save (
  input  logic clk,
  input  logic rst_n,
  input  logic capture,
  input  logic osc_hi_in,
  input  logic sel_hi_in,
  output logic osc_hi_saved,
  output logic sel_hi_saved
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      osc_hi_saved <= 1'b0;
      sel_hi_saved <= 1'b0;
    end else if (capture) begin
      osc_hi_saved <= osc_hi_in;
      sel_hi_saved <= sel_hi_in;
    end
  end

  // R4: saved context only changes on a capture
  a_r4_ctx_stable: assert property (@(posedge clk) disable iff (!rst_n)
    !capture |=> ($stable(osc_hi_saved) && $stable(sel_hi_saved)));

endmodule

// File: rtl/sbc_stab_counter.sv
module sbc_stab_counter #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             active,
  input  logic             tick,
  output logic             underflow
);

  localparam logic [CNT_W-1:0] ZERO = '0;
  localparam logic [CNT_W-1:0] ONE  = {{(CNT_W-1){1'b0}}, 1'b1};

  logic [CNT_W-1:0] cnt_q;
  logic             at_zero;
  logic             step;

  assign at_zero   = (cnt_q == ZERO);
  assign step      = active && tick && !at_zero;
  assign underflow = active && tick && at_zero;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cnt_q <= ZERO;
    else if (load) cnt_q <= load_val;
    else if (step) cnt_q <= cnt_q - ONE;
  end

  // R6: each tick during the wait removes exactly one count
  a_r6_count_down: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !load) |=> (cnt_q == $past(cnt_q) - ONE));

  // R6: no tick, no change
  a_r6_hold_no_tick: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && !tick) |=> $stable(cnt_q));

endmodule

// File: rtl/sbc_mode_fsm.sv
module sbc_mode_fsm
  import sbc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       halt_req,
  input  logic       sleep_req,
  input  logic       wake,
  input  logic       need_wait,
  input  logic       underflow,
  output sbc_state_e state,
  output logic       enter_sleep,
  output logic       start_wait,
  output logic       gate_open,
  output logic       waiting
);

  sbc_state_e state_q, state_d;

  assign enter_sleep = (state_q == ST_RUN) && sleep_req;
  assign start_wait  = (state_q == ST_SLEEP) && wake && need_wait;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_RUN: begin
        if (sleep_req)     state_d = ST_SLEEP;
        else if (halt_req) state_d = ST_HALT;
      end
      ST_HALT:  if (wake) state_d = ST_RUN;
      ST_SLEEP: if (wake) state_d = need_wait ? ST_STAB : ST_RUN;
      ST_STAB:  if (underflow) state_d = ST_RUN;
      default:  state_d = ST_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_RUN;
    else        state_q <= state_d;
  end

  assign state     = state_q;
  assign gate_open = (state_q == ST_RUN);
  assign waiting   = (state_q == ST_STAB);

  // R9: halt exit opens the gate on the next cycle
  a_r9_halt_no_wait: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_HALT && wake) |=> gate_open);

  // R8: sleep exit without a wait opens the gate on the next cycle
  a_r8_no_wait_open: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_SLEEP && wake && !need_wait) |=> (gate_open && !waiting));

  // R6: gate stays shut through the wait until underflow
  a_r6_gate_held: assert property (@(posedge clk) disable iff (!rst_n)
    (waiting && !underflow) |=> !gate_open);

  // R7: underflow releases the gate
  a_r7_uf_opens: assert property (@(posedge clk) disable iff (!rst_n)
    (waiting && underflow) |=> gate_open);

  // R10: sleep wins over a simultaneous halt
  a_r10_sleep_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_RUN && sleep_req && halt_req) |=> (state_q == ST_SLEEP));

  // R5: wake in run mode changes nothing
  a_r5_wake_in_run: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_RUN && wake && !halt_req && !sleep_req) |=> gate_open);

endmodule

// File: rtl/sbc_standby_gate.sv
module sbc_standby_gate
  import sbc_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             halt_req,
  input  logic             sleep_req,
  input  logic             wake_nmi,
  input  logic             wake_port,
  input  logic             wake_timer,
  input  logic             osc_hi_cfg,
  input  logic             osc_lo_cfg,
  input  logic             cpu_sel_hi_cfg,
  input  logic             wait_en_n,
  input  logic [CNT_W-1:0] wait_preset,
  input  logic             hs_tick,
  output logic             osc_hi_en,
  output logic             osc_lo_en,
  output logic             cpu_sel_hi,
  output logic             cpu_clk_en,
  output logic             stab_wait,
  output logic             stab_done
);

  sbc_state_e state;
  logic wake_any, need_wait, enter_sleep, start_wait;
  logic osc_saved, sel_saved, underflow, gate_open, waiting;

  assign wake_any  = wake_nmi | wake_port | wake_timer;
  assign need_wait = wait_needed(wait_en_n, osc_saved, sel_saved);

  sbc_ctx_save u_ctx (
    .clk          (clk),
    .rst_n        (rst_n),
    .capture      (enter_sleep),
    .osc_hi_in    (osc_hi_cfg),
    .sel_hi_in    (cpu_sel_hi_cfg),
    .osc_hi_saved (osc_saved),
    .sel_hi_saved (sel_saved)
  );

  sbc_mode_fsm u_fsm (
    .clk         (clk),
    .rst_n       (rst_n),
    .halt_req    (halt_req),
    .sleep_req   (sleep_req),
    .wake        (wake_any),
    .need_wait   (need_wait),
    .underflow   (underflow),
    .state       (state),
    .enter_sleep (enter_sleep),
    .start_wait  (start_wait),
    .gate_open   (gate_open),
    .waiting     (waiting)
  );

  sbc_stab_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (start_wait),
    .load_val  (wait_preset),
    .active    (waiting),
    .tick      (hs_tick),
    .underflow (underflow)
  );

  always_comb begin
    unique case (state)
      ST_SLEEP: osc_hi_en = 1'b0;
      ST_STAB:  osc_hi_en = osc_saved;
      default:  osc_hi_en = osc_hi_cfg;
    endcase
  end

  assign cpu_sel_hi = (state == ST_SLEEP || state == ST_STAB) ? sel_saved : cpu_sel_hi_cfg;
  assign osc_lo_en  = osc_lo_cfg;
  assign cpu_clk_en = gate_open;
  assign stab_wait  = waiting;
  assign stab_done  = underflow;

  // R2: accepted sleep turns the high-speed oscillator and CPU clock off
  a_r2_sleep_osc_off: assert property (@(posedge clk) disable iff (!rst_n)
    enter_sleep |=> (!osc_hi_en && !cpu_clk_en));

  // R3: the wait only ever runs with the oscillator on
  a_r3_osc_on_in_wait: assert property (@(posedge clk) disable iff (!rst_n)
    start_wait |=> osc_hi_en);

  // R7: underflow is a single-cycle pulse
  a_r7_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    stab_done |=> !stab_done);

  // R6: gate and wait status never both high
  a_r6_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({cpu_clk_en, stab_wait}));

endmodule

// File: tb/sbc_standby_gate_test.sv
module sbc_standby_gate_test;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic halt_req = 0, sleep_req = 0, wake_nmi = 0, wake_port = 0, wake_timer = 0;
  logic osc_hi_cfg = 1, osc_lo_cfg = 1, cpu_sel_hi_cfg = 1, wait_en_n = 0, hs_tick = 0;
  logic [7:0] wait_preset = 8'd3;
  logic osc_hi_en, osc_lo_en, cpu_sel_hi, cpu_clk_en, stab_wait, stab_done;

  int vectors = 0;
  int fails = 0;
  bit done = 0;

  always #5 clk = ~clk;

  sbc_standby_gate uut (
    .clk(clk), .rst_n(rst_n), .halt_req(halt_req), .sleep_req(sleep_req),
    .wake_nmi(wake_nmi), .wake_port(wake_port), .wake_timer(wake_timer),
    .osc_hi_cfg(osc_hi_cfg), .osc_lo_cfg(osc_lo_cfg), .cpu_sel_hi_cfg(cpu_sel_hi_cfg),
    .wait_en_n(wait_en_n), .wait_preset(wait_preset), .hs_tick(hs_tick),
    .osc_hi_en(osc_hi_en), .osc_lo_en(osc_lo_en), .cpu_sel_hi(cpu_sel_hi),
    .cpu_clk_en(cpu_clk_en), .stab_wait(stab_wait), .stab_done(stab_done)
  );

  // Behavioural reference: mode 0 run, 1 halted, 2 asleep, 3 waiting
  int m_mode = 0;
  int m_left = 0;
  bit m_osc = 0, m_sel = 0;

  always @(posedge clk) begin
    bit wk;
    wk = wake_nmi || wake_port || wake_timer;
    if (!rst_n) begin
      m_mode = 0; m_left = 0; m_osc = 0; m_sel = 0;
    end else if (m_mode == 0) begin
      if (sleep_req) begin m_osc = osc_hi_cfg; m_sel = cpu_sel_hi_cfg; m_mode = 2; end
      else if (halt_req) m_mode = 1;
    end else if (m_mode == 1) begin
      if (wk) m_mode = 0;
    end else if (m_mode == 2) begin
      if (wk) begin
        if (wait_en_n == 0 && m_osc && m_sel) begin m_mode = 3; m_left = wait_preset + 1; end
        else m_mode = 0;
      end
    end else begin
      if (hs_tick) begin
        m_left = m_left - 1;
        if (m_left == 0) m_mode = 0;
      end
    end
  end

  task automatic check(input string tag, input logic act, input logic exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s at %0t: actual %b expected %b", tag, $time, act, exp);
    end
  endtask

  // per-cycle compare just before each rising edge
  always @(negedge clk) begin
    #4;
    if (rst_n) begin
      check("R6 cpu_clk_en", cpu_clk_en, m_mode == 0);
      check("R6 stab_wait", stab_wait, m_mode == 3);
      check("R7 stab_done", stab_done, m_mode == 3 && hs_tick && m_left == 1);
      check("R2 osc_hi_en", osc_hi_en, m_mode == 2 ? 1'b0 : (m_mode == 3 ? 1'b1 : osc_hi_cfg));
      check("R4 cpu_sel_hi", cpu_sel_hi, (m_mode >= 2) ? m_sel : cpu_sel_hi_cfg);
      check("R1 osc_lo_en", osc_lo_en, osc_lo_cfg);
    end
  end

  task automatic cyc(input bit h, input bit s, input bit n, input bit p,
                     input bit t, input bit k);
    @(negedge clk);
    halt_req = h; sleep_req = s; wake_nmi = n; wake_port = p; wake_timer = t; hs_tick = k;
    #4;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) cyc(0, 0, 0, 0, 0, 0);
  endtask

  initial begin
    #1;
    check("R11 gate in reset", cpu_clk_en, 1'b1);
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    idle(1);
    check("R11 gate after reset", cpu_clk_en, 1'b1);
    check("R11 wait after reset", stab_wait, 1'b0);
    check("R11 done after reset", stab_done, 1'b0);

    // R1 / R9: halt with wait enabled; exit does not wait
    cyc(1, 0, 0, 0, 0, 0); idle(1);
    check("R1 halt gate", cpu_clk_en, 1'b0);
    check("R1 halt osc_hi", osc_hi_en, 1'b1);
    idle(2);
    cyc(0, 0, 1, 0, 0, 0); idle(1);
    check("R9 halt exit", cpu_clk_en, 1'b1);

    // R2 / R3 / R6 / R7: sleep, wake on port, preset 3 -> 4 ticks
    wait_preset = 8'd3;
    cyc(0, 1, 0, 0, 0, 0); idle(1);
    check("R2 sleep osc off", osc_hi_en, 1'b0);
    cyc(0, 0, 0, 1, 0, 0); idle(1);
    check("R6 waiting", stab_wait, 1'b1);
    check("R3 osc on in wait", osc_hi_en, 1'b1);
    for (int i = 0; i < 3; i++) begin
      cyc(0, 0, 0, 0, 0, 1); idle(1);
      check("R6 still gated", cpu_clk_en, 1'b0);
    end
    cyc(0, 0, 0, 0, 0, 1);
    check("R7 pulse", stab_done, 1'b1);
    idle(1);
    check("R7 gate opens", cpu_clk_en, 1'b1);
    check("R7 pulse ends", stab_done, 1'b0);

    // R6: preset 0 -> single tick
    wait_preset = 8'd0;
    cyc(0, 1, 0, 0, 0, 0); cyc(0, 0, 0, 0, 1, 0);
    cyc(0, 0, 0, 0, 0, 1);
    check("R6 preset0 pulse", stab_done, 1'b1);
    idle(1);
    check("R6 preset0 open", cpu_clk_en, 1'b1);

    // R8: option off, wake by nmi
    wait_en_n = 1;
    cyc(0, 1, 0, 0, 0, 0); idle(2);
    cyc(0, 0, 1, 0, 0, 0); idle(1);
    check("R8 option off", cpu_clk_en, 1'b1);
    check("R8 no wait", stab_wait, 1'b0);

    // R8 / R4: low-speed CPU clock before sleep
    wait_en_n = 0; cpu_sel_hi_cfg = 0;
    cyc(0, 1, 0, 0, 0, 0); idle(1);
    check("R4 saved select", cpu_sel_hi, 1'b0);
    cyc(0, 0, 0, 0, 1, 0); idle(1);
    check("R8 low clock", cpu_clk_en, 1'b1);
    cpu_sel_hi_cfg = 1;

    // R3: oscillator off before sleep stays off after
    osc_hi_cfg = 0;
    cyc(0, 1, 0, 0, 0, 0); cyc(0, 0, 0, 1, 0, 0); idle(1);
    check("R3 osc stays off", osc_hi_en, 1'b0);
    check("R8 osc off no wait", cpu_clk_en, 1'b1);
    osc_hi_cfg = 1;

    // R5: wake in run ignored; R10: simultaneous strobes -> sleep
    cyc(0, 0, 1, 1, 1, 1); idle(1);
    check("R5 wake in run", cpu_clk_en, 1'b1);
    cyc(1, 1, 0, 0, 0, 0); idle(1);
    check("R10 sleep wins", osc_hi_en, 1'b0);
    cyc(1, 0, 0, 0, 0, 0); idle(1);
    check("R10 halt ignored asleep", osc_hi_en, 1'b0);
    wait_en_n = 1; cyc(0, 0, 0, 0, 1, 0); idle(1);
    wait_en_n = 0;

    // pseudo-random run, compared every cycle against the model
    for (int i = 0; i < 3000; i++) begin
      int r;
      r = $urandom % 64;
      wait_en_n = ($urandom % 4) == 0;
      osc_hi_cfg = ($urandom % 5) != 0;
      cpu_sel_hi_cfg = ($urandom % 5) != 0;
      osc_lo_cfg = $urandom % 2;
      wait_preset = $urandom % 6;
      cyc(r == 1, r == 2, r == 3, r == 4, r == 5, ($urandom % 3) == 0);
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    #2000000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

endmodule